// File: doc/BRIEF.md
# Serial Port Interrupt Flag Controller

This block holds the interrupt flags of a serial port and drives its single interrupt request. The transmitter, the receiver and the error detectors report events as one-cycle strobes. Each strobe sets one flag in an eight-bit flag register. Each flag then clears by its own rule:

- a write of one through the register bus;
- a side effect of reading or writing the port's data register;
- the receiver being switched off.

The shift registers, the data register itself, baud generation and framing sit outside this block. They appear here only as strobes and levels.

An enable register masks the flags. It is changed through two write-one registers: one sets enable bits and the other clears them. Reading either of the two returns the current mask. The clear-to-send pin is asynchronous, so it passes through a synchronizer. Both of its edges then set a flag. The request line is the OR of all flags that are set and enabled.

Top module: `sif_irq_ctrl`

## Requirements
- R1: After reset the flag register reads 0x00, the enable mask reads 0x00 and `irq` is low.
- R2: Flag bit 7 sets when any `ev_err` strobe bit is high. Writing 1 to bit 7 of the flag register (address 0x18) clears it. Writing 0 leaves it unchanged.
- R3: Flag bit 5 sets on `ev_brk` only while `autobaud_en` is high. Writing 1 to bit 5 at 0x18 clears it.
- R4: Flag bit 4 sets on a rising or a falling change of `cts_pin`. It becomes visible after the third rising clock edge that follows the change. Writing 1 to bit 4 at 0x18 clears it.
- R5: Flag bit 3 sets on `ev_start` only while `sof_en` is high. Writing 1 to bit 3 at 0x18 clears it.
- R6: Flag bit 2 sets on `ev_rx_done`. It clears when `dreg_rd` is high or when `rx_en` is low. Bus writes to 0x18 never change it.
- R7: Flag bit 1 sets on `ev_tx_done`. It clears on a write of 1 to bit 1 at 0x18 or when `dreg_wr` is high.
- R8: Flag bit 0 sets on `ev_dre`. Only `dreg_wr` clears it. Bus writes to 0x18 never change it.
- R9: Flag bit 6 and enable bit 6 always read 0, whatever is written.
- R10: When a set event and a clear action hit the same flag in the same cycle, the flag ends up set.
- R11: Writing to 0x16 sets every enable bit whose data bit is 1. Writing to 0x14 clears every enable bit whose data bit is 1. Data bits of 0 leave the mask unchanged. Reading 0x14 or 0x16 returns the mask.
- R12: `irq` is high in exactly the cycles in which some flag and its enable bit are both 1. There is no added latency beyond the flag register.
- R13: Reading 0x18 returns the flag register. Any address other than 0x14, 0x16 and 0x18 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (8) | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from address |
| dreg_wr | input | 1 | Data register written this cycle |
| dreg_rd | input | 1 | Data register read this cycle |
| rx_en | input | 1 | Receiver enabled level |
| ev_err | input | N_ERR (5) | Error strobes: collision, sync field, overflow, framing, parity |
| ev_brk | input | 1 | Break character received |
| autobaud_en | input | 1 | Auto-baud framing active |
| cts_pin | input | 1 | Asynchronous clear-to-send pin |
| ev_start | input | 1 | Start condition seen on receive line |
| sof_en | input | 1 | Start-of-frame detection enabled |
| ev_rx_done | input | 1 | Received data became available |
| ev_tx_done | input | 1 | Transmit frame finished and nothing waiting |
| ev_dre | input | 1 | Data register is empty |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check four things:
- the reserved bits stay zero;
- `irq` only rises when some flag and its enable bit are both set;
- the error flag follows its strobes, and the transmit-complete flag survives a data write that arrives in the same cycle;
- the data-empty flag is not cleared by the bus, the receive flag clears when the receiver is off, and the break and start flags stay low while their qualifiers block them.

The bench scenarios cover the remaining behaviour. These are the three-edge latency of the clear-to-send path, the write-zero and write-one rules on each flag, the read map, and the interplay of enable sets and clears with flags that change underneath them.

// File: rtl/sif_pkg.sv
// Shared constants for the serial interrupt flag controller.
// Assumes an eight-bit flag register with fixed bit positions that software decodes.
package sif_pkg;
    localparam int FLAG_W   = 8;
    localparam int B_ERR    = 7;
    localparam int B_RSVD   = 6;
    localparam int B_BRK    = 5;
    localparam int B_CTS    = 4;
    localparam int B_START  = 3;
    localparam int B_RXC    = 2;
    localparam int B_TXC    = 1;
    localparam int B_DRE    = 0;

    // Bits that a bus write of one may clear.
    localparam logic [FLAG_W-1:0] W1C_MASK = (FLAG_W'(1) << B_ERR) | (FLAG_W'(1) << B_BRK)
                                           | (FLAG_W'(1) << B_CTS) | (FLAG_W'(1) << B_START)
                                           | (FLAG_W'(1) << B_TXC);
    // Bits that physically exist (reserved bit removed).
    localparam logic [FLAG_W-1:0] LIVE_MASK = ~(FLAG_W'(1) << B_RSVD);
endpackage

// File: rtl/sif_cts_edge.sv
// Synchronizes the asynchronous clear-to-send pin and flags either edge.
// Assumes the pin is held steady across reset; edge_o is a one-cycle pulse.
module sif_cts_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic edge_o
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    // Shift the pin through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN-2:0], pin_i};
    end

    // Any difference between the last synchronized value and its history is an edge.
    always_comb edge_o = chain_q[CHAIN-1] ^ chain_q[CHAIN-2];
endmodule

// File: rtl/sif_flag_cell.sv
// One interrupt flag: set dominates clear so that no event is lost.
// Assumes set_i and clr_i are already qualified by the caller.
module sif_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Hold, clear or set the flag; set wins a same-cycle conflict.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= 1'b0;
        else if (set_i)  q_o <= 1'b1;
        else if (clr_i)  q_o <= 1'b0;
    end
endmodule

// File: rtl/sif_enable_reg.sv
// Interrupt enable mask changed through separate write-one set and clear strobes.
// Assumes set_we and clr_we are never high together (distinct addresses).
module sif_enable_reg #(
    parameter int              W    = 8,
    parameter logic [W-1:0]    MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_o
);
    logic [W-1:0] en_q;

    // Apply write-one set or write-one clear to the mask.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (set_we) en_q <= (en_q | wdata) & MASK;
        else if (clr_we) en_q <= en_q & ~wdata;
    end

    // Expose the mask.
    always_comb en_o = en_q;
endmodule

// File: rtl/sif_irq_ctrl.sv
// Top of the serial interrupt flag controller: flag register, enable mask,
// read mux and request line. Assumes single-cycle event strobes and a
// combinational read path sampled by the bus in the same cycle.
module sif_irq_ctrl
    import sif_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                N_ERR       = 5,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] ADDR_EN_CLR = ADDR_W'(8'h14),
    parameter logic [ADDR_W-1:0] ADDR_EN_SET = ADDR_W'(8'h16),
    parameter logic [ADDR_W-1:0] ADDR_FLAG   = ADDR_W'(8'h18)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              dreg_wr,
    input  logic              dreg_rd,
    input  logic              rx_en,
    input  logic [N_ERR-1:0]  ev_err,
    input  logic              ev_brk,
    input  logic              autobaud_en,
    input  logic              cts_pin,
    input  logic              ev_start,
    input  logic              sof_en,
    input  logic              ev_rx_done,
    input  logic              ev_tx_done,
    input  logic              ev_dre,
    output logic              irq
);
    logic              cts_edge;
    logic              wr_flag;
    logic              wr_en_set;
    logic              wr_en_clr;
    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] clr_vec;
    logic [FLAG_W-1:0] flag_q;
    logic [FLAG_W-1:0] en_q;

    // Clear-to-send synchronizer and edge detector.
    sif_cts_edge #(.STAGES(SYNC_STAGES)) u_cts (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (cts_pin),
        .edge_o (cts_edge)
    );

    // Decode bus writes to the three registers.
    always_comb begin
        wr_flag   = bus_wr && (bus_addr == ADDR_FLAG);
        wr_en_set = bus_wr && (bus_addr == ADDR_EN_SET);
        wr_en_clr = bus_wr && (bus_addr == ADDR_EN_CLR);
    end

    // Qualify each flag's set event.
    always_comb begin
        set_vec          = '0;
        set_vec[B_ERR]   = |ev_err;
        set_vec[B_BRK]   = ev_brk && autobaud_en;
        set_vec[B_CTS]   = cts_edge;
        set_vec[B_START] = ev_start && sof_en;
        set_vec[B_RXC]   = ev_rx_done;
        set_vec[B_TXC]   = ev_tx_done;
        set_vec[B_DRE]   = ev_dre;
    end

    // Collect each flag's clear rule: bus write-one plus data-path side effects.
    always_comb begin
        clr_vec        = wr_flag ? (bus_wdata & W1C_MASK) : '0;
        clr_vec[B_RXC] = dreg_rd || !rx_en;
        clr_vec[B_TXC] = clr_vec[B_TXC] || dreg_wr;
        clr_vec[B_DRE] = dreg_wr;
    end

    // One flag cell per live bit; the reserved bit is tied low.
    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        if (LIVE_MASK[i]) begin : g_live
            sif_flag_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (set_vec[i]),
                .clr_i (clr_vec[i]),
                .q_o   (flag_q[i])
            );
        end else begin : g_rsvd
            assign flag_q[i] = 1'b0;
        end
    end

    // Enable mask with write-one set and clear registers.
    sif_enable_reg #(.W(FLAG_W), .MASK(LIVE_MASK)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (wr_en_set),
        .clr_we (wr_en_clr),
        .wdata  (bus_wdata),
        .en_o   (en_q)
    );

    // Read mux by address; unmapped addresses read zero.
    always_comb begin
        if (bus_addr == ADDR_FLAG)
            bus_rdata = flag_q;
        else if ((bus_addr == ADDR_EN_SET) || (bus_addr == ADDR_EN_CLR))
            bus_rdata = en_q;
        else
            bus_rdata = '0;
    end

    // Request line: any enabled flag.
    always_comb irq = |(flag_q & en_q);
endmodule

// File: rtl/sif_irq_ctrl_chk.sv
// Property checker for sif_irq_ctrl, attached by bind below.
// Assumes access to the flag and enable registers of the top.
module sif_irq_ctrl_chk #(
    parameter int N_ERR = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dreg_wr,
    input logic             rx_en,
    input logic [N_ERR-1:0] ev_err,
    input logic             ev_brk,
    input logic             autobaud_en,
    input logic             ev_start,
    input logic             sof_en,
    input logic             ev_rx_done,
    input logic             ev_tx_done,
    input logic [7:0]       flag_q,
    input logic [7:0]       en_q,
    input logic             irq
);
    AST_RSVD_LOW: assert property (@(posedge clk) disable iff (!rst_n) !flag_q[6] && !en_q[6]); // R9
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> ((flag_q & en_q) != 8'h00)); // R12
    AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n) (|ev_err) |=> flag_q[7]); // R2
    AST_TXC_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (ev_tx_done && dreg_wr) |=> flag_q[1]); // R10
    AST_RXC_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (!rx_en && !ev_rx_done) |=> !flag_q[2]); // R6
    AST_DRE_ONLY_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (flag_q[0] && !dreg_wr) |=> flag_q[0]); // R8
    AST_BRK_GATED: assert property (@(posedge clk) disable iff (!rst_n) (!flag_q[5] && !(ev_brk && autobaud_en)) |=> !flag_q[5]); // R3
    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n) (!flag_q[3] && !(ev_start && sof_en)) |=> !flag_q[3]); // R5
endmodule

bind sif_irq_ctrl sif_irq_ctrl_chk #(.N_ERR(N_ERR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dreg_wr     (dreg_wr),
    .rx_en       (rx_en),
    .ev_err      (ev_err),
    .ev_brk      (ev_brk),
    .autobaud_en (autobaud_en),
    .ev_start    (ev_start),
    .sof_en      (sof_en),
    .ev_rx_done  (ev_rx_done),
    .ev_tx_done  (ev_tx_done),
    .flag_q      (flag_q),
    .en_q        (en_q),
    .irq         (irq)
);

// File: tb/test_sif_irq_ctrl.sv
`timescale 1ns/1ps
module test_sif_irq_ctrl;
    localparam logic [7:0] A_CLR  = 8'h14;
    localparam logic [7:0] A_SET  = 8'h16;
    localparam logic [7:0] A_FLAG = 8'h18;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       dreg_wr = 1'b0, dreg_rd = 1'b0, rx_en = 1'b1;
    logic [4:0] ev_err = 5'b0;
    logic       ev_brk = 1'b0, autobaud_en = 1'b0, cts_pin = 1'b0;
    logic       ev_start = 1'b0, sof_en = 1'b0;
    logic       ev_rx_done = 1'b0, ev_tx_done = 1'b0, ev_dre = 1'b0;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sif_irq_ctrl i_sif_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dreg_wr(dreg_wr),
        .dreg_rd(dreg_rd), .rx_en(rx_en), .ev_err(ev_err), .ev_brk(ev_brk),
        .autobaud_en(autobaud_en), .cts_pin(cts_pin), .ev_start(ev_start),
        .sof_en(sof_en), .ev_rx_done(ev_rx_done), .ev_tx_done(ev_tx_done),
        .ev_dre(ev_dre), .irq(irq)
    );

    // Reference model built from the requirements.
    logic [7:0] m_flag, m_en;
    logic       m_s1, m_s2, m_s3;

    function automatic logic [7:0] next_flag(logic [7:0] f, logic cts_chg);
        logic [7:0] s, c;
        s = {|ev_err, 1'b0, ev_brk & autobaud_en, cts_chg, ev_start & sof_en,
             ev_rx_done, ev_tx_done, ev_dre};
        c = (bus_wr && bus_addr == A_FLAG) ? (bus_wdata & 8'hBA) : 8'h00;
        c[2] = dreg_rd | ~rx_en;
        c[1] = c[1] | dreg_wr;
        c[0] = dreg_wr;
        return (f & ~c) | s;
    endfunction

    function automatic logic [7:0] next_en(logic [7:0] e);
        if (bus_wr && bus_addr == A_SET) return (e | bus_wdata) & 8'hBF;
        if (bus_wr && bus_addr == A_CLR) return e & ~bus_wdata;
        return e;
    endfunction

    function automatic logic [7:0] exp_read(logic [7:0] a);
        if (a == A_FLAG) return m_flag;
        if (a == A_SET || a == A_CLR) return m_en;
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = 8'h00; m_en = 8'h00; m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            m_flag = next_flag(m_flag, m_s2 ^ m_s3);
            m_en   = next_en(m_en);
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = cts_pin;
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic idle();
        bus_wr = 0; dreg_wr = 0; dreg_rd = 0; ev_err = 0; ev_brk = 0;
        ev_start = 0; ev_rx_done = 0; ev_tx_done = 0; ev_dre = 0;
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk); idle();
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d; tick();
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        bus_addr = a; #0.1; d = bus_rdata;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(A_FLAG, v); chk("R1 flags", v, 8'h00);
        rd(A_SET, v);  chk("R1 enables", v, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);

        // R2 error summary: each source sets, write zero keeps, write one clears
        for (int i = 0; i < 5; i++) begin
            ev_err = 5'(1 << i); tick();
            rd(A_FLAG, v); chk("R2 err set", v & 8'h80, 8'h80);
            wr(A_FLAG, 8'h00); rd(A_FLAG, v); chk("R2 write zero", v & 8'h80, 8'h80);
            wr(A_FLAG, 8'h80); rd(A_FLAG, v); chk("R2 write one", v & 8'h80, 8'h00);
        end

        // R3 break gated by auto-baud
        ev_brk = 1; tick(); rd(A_FLAG, v); chk("R3 gated", v & 8'h20, 8'h00);
        autobaud_en = 1; ev_brk = 1; tick(); rd(A_FLAG, v); chk("R3 set", v & 8'h20, 8'h20);
        wr(A_FLAG, 8'h20); rd(A_FLAG, v); chk("R3 clear", v & 8'h20, 8'h00);
        autobaud_en = 0;

        // R4 clear-to-send: both edges, three-edge latency
        cts_pin = 1; tick(); tick();
        rd(A_FLAG, v); chk("R4 not yet", v & 8'h10, 8'h00);
        tick(); rd(A_FLAG, v); chk("R4 rise", v & 8'h10, 8'h10);
        wr(A_FLAG, 8'h10); rd(A_FLAG, v); chk("R4 clear", v & 8'h10, 8'h00);
        cts_pin = 0; tick(); tick(); tick();
        rd(A_FLAG, v); chk("R4 fall", v & 8'h10, 8'h10);
        wr(A_FLAG, 8'h10);

        // R5 start detect gated
        ev_start = 1; tick(); rd(A_FLAG, v); chk("R5 gated", v & 8'h08, 8'h00);
        sof_en = 1; ev_start = 1; tick(); rd(A_FLAG, v); chk("R5 set", v & 8'h08, 8'h08);
        wr(A_FLAG, 8'h08); rd(A_FLAG, v); chk("R5 clear", v & 8'h08, 8'h00);
        sof_en = 0;

        // R6 receive flag: bus write ignored, data read or disable clears
        ev_rx_done = 1; tick();
        wr(A_FLAG, 8'hFF); rd(A_FLAG, v); chk("R6 write ignored", v & 8'h04, 8'h04);
        dreg_rd = 1; tick(); rd(A_FLAG, v); chk("R6 read clears", v & 8'h04, 8'h00);
        ev_rx_done = 1; tick();
        rx_en = 0; tick(); rx_en = 1; rd(A_FLAG, v); chk("R6 disable clears", v & 8'h04, 8'h00);

        // R7 transmit complete
        ev_tx_done = 1; tick(); rd(A_FLAG, v); chk("R7 set", v & 8'h02, 8'h02);
        wr(A_FLAG, 8'h02); rd(A_FLAG, v); chk("R7 w1c", v & 8'h02, 8'h00);
        ev_tx_done = 1; tick(); dreg_wr = 1; tick();
        rd(A_FLAG, v); chk("R7 data write clears", v & 8'h02, 8'h00);

        // R8 data register empty
        ev_dre = 1; tick();
        wr(A_FLAG, 8'hFF); rd(A_FLAG, v); chk("R8 write ignored", v & 8'h01, 8'h01);
        dreg_wr = 1; tick(); rd(A_FLAG, v); chk("R8 data write clears", v & 8'h01, 8'h00);

        // R10 set beats clear
        ev_tx_done = 1; dreg_wr = 1; tick();
        rd(A_FLAG, v); chk("R10 txc", v & 8'h02, 8'h02);
        ev_err = 5'b00100; bus_wr = 1; bus_addr = A_FLAG; bus_wdata = 8'h80; tick();
        rd(A_FLAG, v); chk("R10 err", v & 8'h80, 8'h80);
        wr(A_FLAG, 8'hFF); dreg_wr = 1; tick();

        // R9 reserved bit
        wr(A_SET, 8'hFF); rd(A_CLR, v); chk("R9 enable bit6", v, 8'hBF);
        rd(A_FLAG, v); chk("R9 flag bit6", v & 8'h40, 8'h00);

        // R11 enable set and clear, zeros no effect
        wr(A_CLR, 8'h0F); rd(A_SET, v); chk("R11 clear", v, 8'hB0);
        wr(A_SET, 8'h00); rd(A_SET, v); chk("R11 set zero", v, 8'hB0);
        wr(A_CLR, 8'h00); rd(A_CLR, v); chk("R11 clear zero", v, 8'hB0);
        wr(A_SET, 8'h02); rd(A_SET, v); chk("R11 set", v, 8'hB2);

        // R12 request follows enabled flags
        chk("R12 idle", {7'b0, irq}, 8'h00);
        ev_dre = 1; tick(); chk("R12 disabled flag", {7'b0, irq}, 8'h00);
        ev_tx_done = 1; tick(); chk("R12 enabled flag", {7'b0, irq}, 8'h01);
        wr(A_CLR, 8'h02); chk("R12 mask off", {7'b0, irq}, 8'h00);

        // R13 unmapped address
        rd(8'h00, v); chk("R13 unmapped", v, 8'h00);

        // Random phase against the model
        for (int n = 0; n < 3000; n++) begin
            chk("R12 random irq", {7'b0, irq}, {7'b0, |(m_flag & m_en)});
            chk("R13 random read", bus_rdata, exp_read(bus_addr));
            bus_wr      = ($urandom % 4) == 0;
            case ($urandom % 5)
                0: bus_addr = A_CLR;
                1: bus_addr = A_SET;
                2, 3: bus_addr = A_FLAG;
                default: bus_addr = 8'($urandom);
            endcase
            bus_wdata   = 8'($urandom);
            dreg_wr     = ($urandom % 8) == 0;
            dreg_rd     = ($urandom % 8) == 0;
            rx_en       = ($urandom % 16) != 0;
            ev_err      = (($urandom % 6) == 0) ? 5'($urandom) : 5'b0;
            ev_brk      = ($urandom % 5) == 0;
            autobaud_en = $urandom % 2;
            if (($urandom % 10) == 0) cts_pin = ~cts_pin;
            ev_start    = ($urandom % 5) == 0;
            sof_en      = $urandom % 2;
            ev_rx_done  = ($urandom % 5) == 0;
            ev_tx_done  = ($urandom % 5) == 0;
            ev_dre      = ($urandom % 5) == 0;
            @(posedge clk); @(negedge clk);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule